// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the processor-facing register file of a serial port. A word-addressed read/write port reaches seven registers: status, data, baud divisor, three control words and guard time. Bytes from the receive side arrive on a valid/ready byte stream. Bytes that software writes to the data register leave on a transmit strobe. A level interrupt reports that unread receive data is waiting.

Flags change as a side effect of access. A status read drops transmit-complete. A data read consumes the received byte and marks the transmitter empty. A status write can only clear bits. The receive stream is held off while a byte is unread, so no byte is ever overwritten. Baud, guard time and control words 2 and 3 are plain storage for logic outside this block.

Top module: `uart_regfile`

## Requirements
- R1: `rx_ready` is high exactly while the receive-not-empty flag (status bit 5) is clear, and a byte offered while it is low is not taken.
- R2: When control word 1 (word index 3) lacks either peripheral enable (bit 13) or receiver enable (bit 2), an accepted byte is dropped. The status, the data register and `irq` stay unchanged.
- R3: With both enables set, an accepted byte is loaded into the data register and sets receive-not-empty. `irq` rises on the next edge if receive interrupt enable (control word 1 bit 5) is set.
- R4: A status read (word index 0) returns the current status. After the edge, transmit-complete (bit 6) is clear.
- R5: A data read (word index 1) returns the data register masked to 10 bits. It then sets transmit-empty (bit 7), clears receive-not-empty and drops `irq`.
- R6: A status write with a value of at most 0x3FF ANDs that value into the status, and `irq` drops if receive-not-empty ends up clear. A larger value is ignored.
- R7: A data write with a value below 0xF000 drives `tx_valid` high in the same cycle, with `tx_data` equal to the low byte. It then sets transmit-complete and clears transmit-empty. A value of 0xF000 or more does nothing.
- R8: A control word 1 write raises `irq` when the written receive interrupt enable and the current receive-not-empty are both set.
- R9: Reset sets the status to 0xC0 and every other register to zero, with `irq` low.
- R10: Baud (index 2), control 2 (index 4), control 3 (index 5) and guard time (index 6) store and return what is written. Index 7 reads as zero, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Register word index |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe, side effects on the edge |
| reg_wdata | input | DATA_W | Write value |
| reg_rdata | output | DATA_W | Read value, valid in the cycle of `reg_rd` |
| rx_valid | input | 1 | Received byte offered |
| rx_data | input | BYTE_W | Received byte |
| rx_ready | output | 1 | Receive side may hand over a byte |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | BYTE_W | Transmit byte |
| irq | output | 1 | Receive-data interrupt, level |

## Verification
The bench uses the default parameters: 32-bit data, a 3-bit word index and 8-bit bytes. With a 32-bit write value, the bench can reach both write thresholds, 0x3FF on status and 0xF000 on data, from either side. With a 3-bit index, it can reach index 7, the one unmapped slot, and confirm that it reads as zero and ignores writes. The bench tracks flags through chains of reads and writes, because each access depends on the flags left by the previous one.

// File: rtl/uart_regfile.sv
module uart_regfile #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] IX_SR = ADDR_W'(0), IX_DR = ADDR_W'(1), IX_BR = ADDR_W'(2),
                                IX_C1 = ADDR_W'(3), IX_C2 = ADDR_W'(4), IX_C3 = ADDR_W'(5),
                                IX_GT = ADDR_W'(6);
  localparam int F_RXNE = 5, F_TC = 6, F_TXE = 7;
  localparam int C_RE = 2, C_IE = 5, C_UE = 13;
  localparam logic [DATA_W-1:0] SR_INIT  = DATA_W'(32'hC0);
  localparam logic [DATA_W-1:0] SR_LIM   = DATA_W'(32'h3FF);
  localparam logic [DATA_W-1:0] TX_LIM   = DATA_W'(32'hF000);
  localparam logic [DATA_W-1:0] RD_MASK  = DATA_W'(32'h3FF);

  logic [DATA_W-1:0] sr, dr, br, c1, c2, c3, gt;
  logic [DATA_W-1:0] sr_n, c1_n;
  logic              irq_n;

  wire wr_sr = reg_wr && reg_addr == IX_SR && reg_wdata <= SR_LIM;
  wire wr_dr = reg_wr && reg_addr == IX_DR && reg_wdata < TX_LIM;
  wire wr_c1 = reg_wr && reg_addr == IX_C1;
  wire rd_sr = reg_rd && reg_addr == IX_SR;
  wire rd_dr = reg_rd && reg_addr == IX_DR;
  wire rx_take = rx_valid && rx_ready;
  wire rx_keep = rx_take && c1_n[C_UE] && c1_n[C_RE];

  assign rx_ready = !sr[F_RXNE];
  assign tx_valid = wr_dr;
  assign tx_data  = reg_wdata[BYTE_W-1:0];

  always_comb begin
    unique case (reg_addr)
      IX_SR:   reg_rdata = sr;
      IX_DR:   reg_rdata = dr & RD_MASK;
      IX_BR:   reg_rdata = br;
      IX_C1:   reg_rdata = c1;
      IX_C2:   reg_rdata = c2;
      IX_C3:   reg_rdata = c3;
      IX_GT:   reg_rdata = gt;
      default: reg_rdata = '0;
    endcase
  end

  always_comb begin
    sr_n  = sr;
    irq_n = irq;
    c1_n  = wr_c1 ? reg_wdata : c1;
    if (rd_sr) sr_n[F_TC] = 1'b0;
    if (rd_dr) begin
      sr_n[F_TXE]  = 1'b1;
      sr_n[F_RXNE] = 1'b0;
      irq_n        = 1'b0;
    end
    if (wr_sr) begin
      sr_n = sr_n & reg_wdata;
      if (!sr_n[F_RXNE]) irq_n = 1'b0;
    end
    if (wr_dr) begin
      sr_n[F_TC]  = 1'b1;
      sr_n[F_TXE] = 1'b0;
    end
    if (wr_c1 && reg_wdata[C_IE] && sr_n[F_RXNE]) irq_n = 1'b1;
    if (rx_keep) begin
      sr_n[F_RXNE] = 1'b1;
      if (c1_n[C_IE]) irq_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr  <= SR_INIT;
      dr  <= '0;
      br  <= '0;
      c1  <= '0;
      c2  <= '0;
      c3  <= '0;
      gt  <= '0;
      irq <= 1'b0;
    end else begin
      sr  <= sr_n;
      c1  <= c1_n;
      irq <= irq_n;
      if (rx_keep) dr <= DATA_W'(rx_data);
      if (reg_wr && reg_addr == IX_BR) br <= reg_wdata;
      if (reg_wr && reg_addr == IX_C2) c2 <= reg_wdata;
      if (reg_wr && reg_addr == IX_C3) c3 <= reg_wdata;
      if (reg_wr && reg_addr == IX_GT) gt <= reg_wdata;
    end
  end
endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              irq,
  input logic [DATA_W-1:0] sr
);
  localparam logic [DATA_W-1:0] LIM = DATA_W'(32'h3FF);
  localparam logic [DATA_W-1:0] KEEP_RXNE = DATA_W'(32'h20);

  // R3
  irq_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> sr[5]);

  // R1
  rxne_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr[5]) |-> $past(rx_valid && rx_ready));

  // R5
  data_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr && reg_addr == ADDR_W'(1) && !(rx_valid && rx_ready))
      |=> (!irq && sr[7]));

  // R6
  status_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(0) && reg_wdata <= LIM)
      |=> ((sr & ~$past(reg_wdata) & ~KEEP_RXNE) == '0));

  // R9
  reset_irq_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> !irq);
endmodule

bind uart_regfile uart_regfile_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_wdata(reg_wdata), .rx_valid(rx_valid), .rx_ready(rx_ready), .irq(irq), .sr(sr)
);

// File: tb/tb_uart_regfile.sv
module tb_uart_regfile;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 30;
  // kind: 0 write, 1 read and compare, 2 push byte
  localparam logic [68:0] VEC [NV] = '{
    {2'd1, 3'd0, 32'h0,      32'hC0},
    {2'd1, 3'd0, 32'h0,      32'h80},
    {2'd0, 3'd3, 32'h2024,   32'h0},
    {2'd1, 3'd3, 32'h0,      32'h2024},
    {2'd2, 3'd0, 32'h5A,     32'h0},
    {2'd1, 3'd0, 32'h0,      32'hA0},
    {2'd1, 3'd1, 32'h0,      32'h5A},
    {2'd1, 3'd0, 32'h0,      32'h80},
    {2'd0, 3'd1, 32'h41,     32'h0},
    {2'd1, 3'd0, 32'h0,      32'h40},
    {2'd1, 3'd0, 32'h0,      32'h00},
    {2'd0, 3'd2, 32'h1234,   32'h0},
    {2'd1, 3'd2, 32'h0,      32'h1234},
    {2'd0, 3'd6, 32'hABCD,   32'h0},
    {2'd1, 3'd6, 32'h0,      32'hABCD},
    {2'd0, 3'd4, 32'h3000,   32'h0},
    {2'd1, 3'd4, 32'h0,      32'h3000},
    {2'd0, 3'd5, 32'h7,      32'h0},
    {2'd1, 3'd5, 32'h0,      32'h7},
    {2'd2, 3'd0, 32'h33,     32'h0},
    {2'd0, 3'd0, 32'h400,    32'h0},
    {2'd1, 3'd0, 32'h0,      32'h20},
    {2'd0, 3'd0, 32'h3DF,    32'h0},
    {2'd1, 3'd0, 32'h0,      32'h00},
    {2'd1, 3'd7, 32'h0,      32'h0},
    {2'd0, 3'd7, 32'hFFFF,   32'h0},
    {2'd1, 3'd0, 32'h0,      32'h00},
    {2'd1, 3'd2, 32'h0,      32'h1234},
    {2'd1, 3'd1, 32'h0,      32'h33},
    {2'd1, 3'd0, 32'h0,      32'h80}
  };

  logic clk = 0, rst_n = 0;
  logic [2:0] reg_addr = '0;
  logic reg_wr = 0, reg_rd = 0, rx_valid = 0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [7:0] rx_data = '0, tx_data;
  logic rx_ready, tx_valid, irq;
  int checks = 0, errors = 0;
  logic [31:0] got;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_regfile dut (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    #1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; reg_rd = 1;
    #1 v = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic push(logic [7:0] b);
    @(negedge clk); rx_data = b; rx_valid = 1;
    @(negedge clk); rx_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R9 irq", 32'(irq), 0);
    chk("R9 rx_ready", 32'(rx_ready), 1);
    chk("R9 tx_valid", 32'(tx_valid), 0);
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][68:67])
        2'd0: wr(VEC[i][66:64], VEC[i][63:32]);
        2'd2: push(VEC[i][39:32]);
        default: begin
          rd(VEC[i][66:64], got);
          chk($sformatf("R4 R5 R6 R9 R10 vec %0d", i), got, VEC[i][31:0]);
        end
      endcase
    end

    wr(3'd3, 32'h2004);
    push(8'hA1);
    #1 chk("R1 ready low", 32'(rx_ready), 0);
    chk("R3 no ie irq low", 32'(irq), 0);
    push(8'hB2);
    rd(3'd1, got);
    chk("R1 held byte", got, 32'hA1);
    wr(3'd3, 32'h2004);
    wr(3'd3, 32'h0004);
    push(8'h77);
    rd(3'd0, got);
    chk("R2 status", got, 32'h80);
    rd(3'd1, got);
    chk("R2 data", got, 32'hA1);
    wr(3'd3, 32'h2024);
    push(8'h5C);
    #1 chk("R3 irq", 32'(irq), 1);
    rd(3'd1, got);
    #1 chk("R5 irq drop", 32'(irq), 0);
    wr(3'd3, 32'h2004);
    push(8'h11);
    wr(3'd3, 32'h2024);
    #1 chk("R8 irq", 32'(irq), 1);
    wr(3'd0, 32'h3FF);
    #1 chk("R6 irq kept", 32'(irq), 1);
    wr(3'd0, 32'hDF);
    #1 chk("R6 irq cleared", 32'(irq), 0);
    @(negedge clk); reg_addr = 3'd1; reg_wdata = 32'h1C5; reg_wr = 1;
    #1;
    chk("R7 tx_valid", 32'(tx_valid), 1);
    chk("R7 tx_data", 32'(tx_data), 32'hC5);
    @(negedge clk); reg_wr = 0;
    rd(3'd0, got);
    chk("R7 status", got, 32'h40);
    @(negedge clk); reg_addr = 3'd1; reg_wdata = 32'hF000; reg_wr = 1;
    #1 chk("R7 big no tx", 32'(tx_valid), 0);
    @(negedge clk); reg_wr = 0;
    rd(3'd0, got);
    chk("R7 big no flags", got, 32'h00);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule